// File: doc/BRIEF.md
# Receive Destination Address Filter with Station Table

This block decides, one frame at a time, whether a received Ethernet frame is addressed to this station. The 48-bit destination address is compared against a table of sixteen station addresses, each entry switched in or out by its own bit in an enable mask. Three mode inputs widen acceptance: promiscuous (every individual address), all-group (every address with the group bit set) and broadcast (the all-ones address). The result, accept or reject plus a two-bit frame-type code, appears one clock after the destination is presented.

Software fills the table through a word-at-a-time load port driven by a small state machine. A load command carries a 5-bit entry count. For each entry the machine takes an index word, whose low four bits choose the entry, and then three address words, first word holding the first two destination bytes. It counts down after each entry and, once the count reaches zero, takes one final word as the enable mask and reports completion. States: `LS_IDLE` (waiting; `ld_start` with a non-zero count goes to `LS_IDX`, with a zero count to `LS_MASK`), `LS_IDX` (index word, then `LS_W0`), `LS_W0` and `LS_W1` (address words, each advancing to the next), `LS_W2` (last address word; back to `LS_IDX` while entries remain, otherwise `LS_MASK`), `LS_MASK` (mask word, then `LS_IDLE` with done set). Each state advances only on a cycle with `ld_valid` high. While the surrounding device is held in its reset state, any entry word can be read back.

Top module: `cam_addr_filter`

## Requirements
- R1: After reset the load machine is idle (`ld_busy`=0, `ld_done`=0), no result is reported (`f_res_valid`=0), and the enable mask is zero so no table match can occur.
- R2: With `mode_prom`=1, a destination whose first byte has bit 0 clear (bit 40 of `f_dst`) is accepted with `f_type`=2'b00.
- R3: With `mode_allmc`=1, a destination whose bit 40 is set is accepted with `f_type`=2'b10 (bit 1 = group flag).
- R4: With `mode_bcast`=1, the all-ones destination is accepted with `f_type`=2'b01 (bit 0 = broadcast flag).
- R5: A destination equal to an entry whose enable bit is set is accepted; `f_type` is 2'b01 if the address is all ones, 2'b10 if bit 40 is otherwise set, else 2'b00.
- R6: A destination matched by no mode and by no enabled entry, including one equal to a disabled entry, is rejected with `f_type`=2'b00.
- R7: The checks are applied in the order promiscuous, all-group, broadcast, table; the first that hits sets `f_type` (so broadcast under all-group reports 2'b10).
- R8: `f_res_valid` is high exactly in the cycle after each cycle with `f_valid` high, with the result for that destination; back-to-back destinations give back-to-back results.
- R9: On `ld_start` the machine latches `ld_count`; per entry it takes an index word (only bits 3:0 used) and three address words (word 0 = `f_dst[47:32]`, word 1 = `[31:16]`, word 2 = `[15:0]`), decrements the count, and repeats while it is non-zero; a count of zero skips straight to the mask word.
- R10: The word after the last entry becomes the enable mask (bit i enables entry i); in that cycle the machine returns to idle, `ld_busy` drops and `ld_done` is set and stays set until the next `ld_start`.
- R11: `rd_data` returns word `rd_word` (0..2, same numbering as R9) of entry `rd_entry` while `in_reset`=1, and reads 0 while `in_reset`=0.
- R12: `ld_valid` words presented while the machine is idle change no entry and no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_prom | input | 1 | Accept every individual address |
| mode_allmc | input | 1 | Accept every group address |
| mode_bcast | input | 1 | Accept the all-ones address |
| f_valid | input | 1 | Destination address present this cycle |
| f_dst | input | 48 | Destination; bits 47:40 are the first byte |
| f_res_valid | output | 1 | Result valid (one cycle after `f_valid`) |
| f_accept | output | 1 | Frame accepted |
| f_type | output | 2 | Bit 0 broadcast, bit 1 group |
| ld_start | input | 1 | Begin a table load |
| ld_count | input | 5 | Number of entries in the load |
| ld_valid | input | 1 | Load word present this cycle |
| ld_word | input | 16 | Load word (index, address or mask) |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | Sticky load-complete status |
| in_reset | input | 1 | Device held in its reset state; enables readback |
| rd_entry | input | 4 | Readback entry select |
| rd_word | input | 2 | Readback word select |
| rd_data | output | 16 | Readback data |

## Verification
Destinations are drawn from individual addresses, group addresses and the all-ones address, each tried with every mode off, with one mode on and with overlapping modes; the off case separates a true table hit from a mode hit, and the overlaps expose the evaluation order through the type code. Table patterns include an index word with high bits set, an entry later disabled by a zero-count reload, and a group address stored in the table, which tells the mask path, the count-zero transition and the address-derived type apart. Back-to-back strobes separate a registered result from a held one, and readback with the reset flag high and low shows the gating.

// File: rtl/camf_pkg.sv
package camf_pkg;
    typedef enum logic [2:0] {
        LS_IDLE,
        LS_IDX,
        LS_W0,
        LS_W1,
        LS_W2,
        LS_MASK
    } ld_state_e;

    localparam int TYPE_BC = 0;
    localparam int TYPE_MC = 1;
endpackage

// File: rtl/camf_store.sv
module camf_store #(
    parameter int N_ENT   = 16,
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 3,
    localparam int IDX_W  = $clog2(N_ENT),
    localparam int SEL_W  = $clog2(N_WORDS),
    localparam int ADDR_W = WORD_W * N_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              mask_we,
    input  logic [N_ENT-1:0]  mask_data,
    input  logic [ADDR_W-1:0] probe,
    output logic              hit,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] ent [N_ENT][N_WORDS];
    logic [N_ENT-1:0]  mask;
    logic [N_ENT-1:0]  hitv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
            for (int e = 0; e < N_ENT; e++)
                for (int w = 0; w < N_WORDS; w++)
                    ent[e][w] <= '0;
        end else begin
            if (wr_en && (int'(wr_sel) < N_WORDS))
                ent[wr_idx][wr_sel] <= wr_data;
            if (mask_we)
                mask <= mask_data;
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic [ADDR_W-1:0] flat;
        always_comb begin
            for (int w = 0; w < N_WORDS; w++)
                flat[ADDR_W-1-w*WORD_W -: WORD_W] = ent[g][w];
        end
        assign hitv[g] = mask[g] && (flat == probe);
    end

    assign hit = |hitv;

    always_comb begin
        if (int'(rd_sel) < N_WORDS)
            rd_data = ent[rd_idx][rd_sel];
        else
            rd_data = '0;
    end

    // R10: the mask word lands in the mask register one edge later
    a_r10_mask_taken: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask == $past(mask_data));
    // R1: with no enable bit set no entry can hit
    a_r1_no_hit_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !hit);
endmodule

// File: rtl/camf_load_fsm.sv
module camf_load_fsm #(
    parameter int N_ENT  = 16,
    parameter int CNT_W  = 5,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             valid,
    input  logic [IDX_W-1:0] idx_in,
    output logic             busy,
    output logic             done,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [1:0]       wr_sel,
    output logic             mask_we
);
    import camf_pkg::*;

    ld_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;

    always_comb begin
        state_nx = state;
        unique case (state)
            LS_IDLE: if (start) state_nx = (count != '0) ? LS_IDX : LS_MASK;
            LS_IDX:  if (valid) state_nx = LS_W0;
            LS_W0:   if (valid) state_nx = LS_W1;
            LS_W1:   if (valid) state_nx = LS_W2;
            LS_W2:   if (valid) state_nx = (cnt == CNT_W'(1)) ? LS_MASK : LS_IDX;
            LS_MASK: if (valid) state_nx = LS_IDLE;
            default: state_nx = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            if (state == LS_IDLE && start) begin
                cnt  <= count;
                done <= 1'b0;
            end
            if (state == LS_IDX && valid) idx <= idx_in;
            if (state == LS_W2 && valid)  cnt <= cnt - CNT_W'(1);
            if (state == LS_MASK && valid) done <= 1'b1;
        end
    end

    always_comb begin
        busy    = (state != LS_IDLE);
        wr_en   = 1'b0;
        wr_sel  = 2'd0;
        mask_we = 1'b0;
        wr_idx  = idx;
        unique case (state)
            LS_W0:   begin wr_en = valid; wr_sel = 2'd0; end
            LS_W1:   begin wr_en = valid; wr_sel = 2'd1; end
            LS_W2:   begin wr_en = valid; wr_sel = 2'd2; end
            LS_MASK: mask_we = valid;
            default: ;
        endcase
    end

    // R9: an entry loop is only ever entered with entries left to take
    a_r9_loop_has_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_IDX || state == LS_W0 || state == LS_W1 || state == LS_W2) |-> cnt != '0);
    // R10: the mask word ends the load with done set
    a_r10_done_after_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_MASK && valid) |=> (done && !busy));
    // R12: while idle no table write is issued
    a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(wr_en || mask_we));
endmodule

// File: rtl/camf_decide.sv
module camf_decide #(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prom,
    input  logic              allmc,
    input  logic              bcast,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] dst,
    input  logic              hit,
    output logic              res_valid,
    output logic              accept,
    output logic [1:0]        ftype
);
    import camf_pkg::*;

    logic       grp, is_bc, acc_d;
    logic [1:0] typ_d;

    assign grp   = dst[ADDR_W-8];
    assign is_bc = &dst;

    always_comb begin
        acc_d = 1'b0;
        typ_d = 2'b00;
        if (prom && !grp) begin
            acc_d = 1'b1;
        end else if (allmc && grp) begin
            acc_d = 1'b1;
            typ_d[TYPE_MC] = 1'b1;
        end else if (bcast && is_bc) begin
            acc_d = 1'b1;
            typ_d[TYPE_BC] = 1'b1;
        end else if (hit) begin
            acc_d = 1'b1;
            typ_d[TYPE_BC] = is_bc;
            typ_d[TYPE_MC] = grp && !is_bc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            accept    <= 1'b0;
            ftype     <= 2'b00;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                accept <= acc_d;
                ftype  <= typ_d;
            end
        end
    end

    // R8: one result per strobe, exactly one cycle later
    a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    // R6: a rejected frame carries no type flag
    a_r6_reject_no_type: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !accept) |-> ftype == 2'b00);
    // R7: broadcast and group flags are never reported together
    a_r7_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot0(ftype));
endmodule

// File: rtl/cam_addr_filter.sv
module cam_addr_filter #(
    parameter int N_ENT   = 16,
    parameter int CNT_W   = 5,
    localparam int WORD_W = 16,
    localparam int N_WORDS = 3,
    localparam int ADDR_W = WORD_W * N_WORDS,
    localparam int IDX_W  = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_prom,
    input  logic              mode_allmc,
    input  logic              mode_bcast,
    input  logic              f_valid,
    input  logic [ADDR_W-1:0] f_dst,
    output logic              f_res_valid,
    output logic              f_accept,
    output logic [1:0]        f_type,
    input  logic              ld_start,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic              ld_valid,
    input  logic [WORD_W-1:0] ld_word,
    output logic              ld_busy,
    output logic              ld_done,
    input  logic              in_reset,
    input  logic [IDX_W-1:0]  rd_entry,
    input  logic [1:0]        rd_word,
    output logic [WORD_W-1:0] rd_data
);
    logic              wr_en, mask_we, hit;
    logic [IDX_W-1:0]  wr_idx;
    logic [1:0]        wr_sel;
    logic [WORD_W-1:0] rd_raw;

    camf_load_fsm #(.N_ENT(N_ENT), .CNT_W(CNT_W)) u_load (
        .clk(clk), .rst_n(rst_n), .start(ld_start), .count(ld_count),
        .valid(ld_valid), .idx_in(ld_word[IDX_W-1:0]), .busy(ld_busy),
        .done(ld_done), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
        .mask_we(mask_we)
    );

    camf_store #(.N_ENT(N_ENT), .WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .wr_data(ld_word), .mask_we(mask_we),
        .mask_data(ld_word[N_ENT-1:0]), .probe(f_dst), .hit(hit),
        .rd_idx(rd_entry), .rd_sel(rd_word), .rd_data(rd_raw)
    );

    camf_decide #(.ADDR_W(ADDR_W)) u_decide (
        .clk(clk), .rst_n(rst_n), .prom(mode_prom), .allmc(mode_allmc),
        .bcast(mode_bcast), .in_valid(f_valid), .dst(f_dst), .hit(hit),
        .res_valid(f_res_valid), .accept(f_accept), .ftype(f_type)
    );

    assign rd_data = in_reset ? rd_raw : '0;

    // R11: readback is closed outside the reset state
    a_r11_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !in_reset |-> rd_data == '0);
endmodule

// File: tb/sim_cam_addr_filter.sv
`timescale 1ns/1ps
module sim_cam_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_prom = 0, mode_allmc = 0, mode_bcast = 0;
    logic        f_valid = 0;
    logic [47:0] f_dst = '0;
    logic        f_res_valid, f_accept;
    logic [1:0]  f_type;
    logic        ld_start = 0;
    logic [4:0]  ld_count = '0;
    logic        ld_valid = 0;
    logic [15:0] ld_word = '0;
    logic        ld_busy, ld_done;
    logic        in_reset = 0;
    logic [3:0]  rd_entry = '0;
    logic [1:0]  rd_word = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    logic [47:0] m_ent [16];
    logic [15:0] m_mask = '0;
    logic        exp_v = 0, exp_a = 0;
    logic [1:0]  exp_t = 2'b00;

    always #2.5 clk = ~clk;

    cam_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .mode_prom(mode_prom), .mode_allmc(mode_allmc),
        .mode_bcast(mode_bcast), .f_valid(f_valid), .f_dst(f_dst),
        .f_res_valid(f_res_valid), .f_accept(f_accept), .f_type(f_type),
        .ld_start(ld_start), .ld_count(ld_count), .ld_valid(ld_valid),
        .ld_word(ld_word), .ld_busy(ld_busy), .ld_done(ld_done),
        .in_reset(in_reset), .rd_entry(rd_entry), .rd_word(rd_word),
        .rd_data(rd_data)
    );

    function automatic logic [2:0] model(input logic [47:0] d);
        logic g, b, h;
        g = d[40];
        b = (d == 48'hFFFF_FFFF_FFFF);
        h = 1'b0;
        for (int i = 0; i < 16; i++)
            if (m_mask[i] && m_ent[i] == d) h = 1'b1;
        if (mode_prom && !g)        return 3'b100;
        if (mode_allmc && g)        return 3'b110;
        if (mode_bcast && b)        return 3'b101;
        if (h) return {1'b1, g && !b, b};
        return 3'b000;
    endfunction

    always @(posedge clk) begin
        logic [2:0] r;
        if (!rst_n) exp_v = 1'b0;
        else begin
            exp_v = f_valid;
            if (f_valid) begin
                r = model(f_dst);
                exp_a = r[2];
                exp_t = r[1:0];
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_v || f_res_valid) begin
                checks++;
                if (f_res_valid !== exp_v) begin
                    errors++;
                    $display("FAIL %s R8 res_valid actual %b expected %b", cur_req, f_res_valid, exp_v);
                end else if (f_accept !== exp_a || f_type !== exp_t) begin
                    errors++;
                    $display("FAIL %s accept/type actual %b/%b expected %b/%b",
                             cur_req, f_accept, f_type, exp_a, exp_t);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 20000 cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [47:0] d);
        @(negedge clk);
        f_valid = 1'b1;
        f_dst = d;
        @(negedge clk);
        f_valid = 1'b0;
    endtask

    task automatic push(input logic [15:0] w);
        ld_valid = 1'b1;
        ld_word = w;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic load_entry(input logic [15:0] iw, input logic [47:0] a);
        push(iw);
        push(a[47:32]);
        push(a[31:16]);
        push(a[15:0]);
        m_ent[iw[3:0]] = a;
    endtask

    task automatic begin_load(input logic [4:0] n);
        @(negedge clk);
        ld_start = 1'b1;
        ld_count = n;
        @(negedge clk);
        ld_start = 1'b0;
        chk("R9 busy after start", {47'd0, ld_busy}, 48'd1);
        chk("R10 done cleared by start", {47'd0, ld_done}, 48'd0);
    endtask

    task automatic finish_load(input logic [15:0] m);
        push(m);
        m_mask = m;
        chk("R10 busy drops", {47'd0, ld_busy}, 48'd0);
        chk("R10 done set", {47'd0, ld_done}, 48'd1);
    endtask

    localparam logic [47:0] UNI_A = 48'h0200_0000_0005;
    localparam logic [47:0] GRP_B = 48'h0100_5E00_0001;
    localparam logic [47:0] UNI_X = 48'h0A1B_2C3D_4E5F;
    localparam logic [47:0] GRP_Y = 48'h3300_0000_00AA;
    localparam logic [47:0] BCST  = 48'hFFFF_FFFF_FFFF;

    initial begin
        for (int i = 0; i < 16; i++) m_ent[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 busy", {47'd0, ld_busy}, 48'd0);
        chk("R1 done", {47'd0, ld_done}, 48'd0);
        chk("R1 res_valid", {47'd0, f_res_valid}, 48'd0);
        send(48'h0);   // all-zero entries exist but none enabled

        // R9: two entries, index word with high bits set selects entry 3
        begin_load(5'd2);
        load_entry(16'hFF13, UNI_A);
        chk("R9 still busy between entries", {47'd0, ld_busy}, 48'd1);
        load_entry(16'h0007, GRP_B);
        finish_load(16'h0088);

        cur_req = "R5";
        send(UNI_A);
        send(GRP_B);
        cur_req = "R6";
        send(UNI_X);
        send(BCST);
        send(GRP_Y);

        // R9 / R10: zero count goes straight to the mask word; disable entry 3
        begin_load(5'd0);
        finish_load(16'h0080);
        cur_req = "R6";
        send(UNI_A);
        cur_req = "R5";
        send(GRP_B);

        cur_req = "R2";
        mode_prom = 1'b1;
        send(UNI_X);
        send(GRP_Y);
        mode_prom = 1'b0;

        cur_req = "R3";
        mode_allmc = 1'b1;
        send(GRP_Y);
        cur_req = "R7";
        send(BCST);
        mode_allmc = 1'b0;

        cur_req = "R4";
        mode_bcast = 1'b1;
        send(BCST);
        cur_req = "R7";
        mode_prom = 1'b1;
        send(BCST);
        send(UNI_X);
        mode_prom = 1'b0;
        mode_bcast = 1'b0;

        // R8: back-to-back strobes
        cur_req = "R8";
        @(negedge clk);
        f_valid = 1'b1; f_dst = GRP_B;
        @(negedge clk);
        f_dst = UNI_X;
        @(negedge clk);
        f_dst = GRP_B;
        @(negedge clk);
        f_valid = 1'b0;
        @(negedge clk);

        // R11: readback gated by reset state
        in_reset = 1'b1;
        rd_entry = 4'd3; rd_word = 2'd0; #1;
        chk("R11 entry3 word0", {32'd0, rd_data}, 48'h0200);
        rd_word = 2'd2; #1;
        chk("R11 entry3 word2", {32'd0, rd_data}, 48'h0005);
        rd_entry = 4'd7; rd_word = 2'd1; #1;
        chk("R11 entry7 word1", {32'd0, rd_data}, 48'h5E00);
        in_reset = 1'b0; #1;
        chk("R11 closed outside reset", {32'd0, rd_data}, 48'h0);

        // R12: words while idle are ignored
        @(negedge clk);
        push(16'h1234);
        push(16'hFFFF);
        in_reset = 1'b1;
        rd_entry = 4'd7; rd_word = 2'd0; #1;
        chk("R12 entry7 word0 unchanged", {32'd0, rd_data}, 48'h0100);
        rd_entry = 4'd4; #1;
        chk("R12 entry4 still empty", {32'd0, rd_data}, 48'h0);
        in_reset = 1'b0;
        chk("R12 still idle", {47'd0, ld_busy}, 48'd0);
        cur_req = "R12";
        send(UNI_A);
        send(GRP_B);

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule